// File: doc/BRIEF.md
# Arithmetic Logic Unit with Sign, Zero, Overflow and Carry Flags

This block is a purely combinational arithmetic logic unit for a datapath of parameterised width (32 bits by default). It takes two operands and a three-bit function code. The top bit of the code chooses between addition and subtraction in a single ripple adder. Subtraction inverts the second operand with XOR gates and forces the adder's carry-in to one. The low two bits of the code steer an output multiplexer. That multiplexer picks either the adder result or one of three bitwise results: AND, OR or XOR of the two operands.

Four condition flags come out beside the result. Sign and zero describe whichever result is selected. Carry and overflow always describe the adder, even when a logic function is selected. Overflow is found by comparing the carry entering the most significant bit with the carry leaving it. The surrounding pipeline stores the flags if it needs them; this unit holds no state.

Top module: `alu_nzvc`

## Requirements
- R1: With function code 3'b000, `result` equals `opa + opb` modulo 2^WIDTH.
- R2: With function code 3'b100, `result` equals `opa - opb` modulo 2^WIDTH, computed as `opa + ~opb + 1`.
- R3: Function code bits [1:0] select the output: 2'b00 adder, 2'b01 `opa & opb`, 2'b10 `opa | opb`, 2'b11 `opa ^ opb`. The logic results use the unmodified `opb` whatever the value of bit 2.
- R4: `flag_n` equals bit WIDTH-1 of `result` for every function code.
- R5: `flag_z` is 1 exactly when every bit of `result` is 0, for every function code.
- R6: `flag_c` is the carry out of the most significant adder bit of `opa + (opb ^ {WIDTH{f2}}) + f2`, where f2 is function bit 2. This holds for every function code, including the logic codes.
- R7: `flag_v` is the XOR of the carry into adder bit WIDTH-1 and the carry out of it, for every function code. For addition and subtraction this means signed overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| func | input | 3 | Bit 2: subtract; bits 1:0: output select |
| result | output | WIDTH | Selected result |
| flag_n | output | 1 | Sign of result |
| flag_z | output | 1 | Result is zero |
| flag_v | output | 1 | Adder signed overflow |
| flag_c | output | 1 | Adder carry out |

## Verification
The block has no state, so any fault shows at the ports in the same evaluation as the operands that expose it.
- A broken carry link in the ripple chain shows as a wrong sum. It only appears for operands whose carry crosses that bit, which is why the all-ones, 0x7FFFFFFF and 0x80000000 corner operands are paired with each other under every code.
- Swapped multiplexer legs show as a wrong result for a logic code.
- A wrong inversion path shows as subtraction results that are off by one, or as logic results taken from the inverted operand.
- Mistakes in flag derivation show as overflow or carry that disagree with the model on the sign-boundary corners.

// File: rtl/alu_pkg.sv
package alu_pkg;
   typedef enum logic [1:0] {
      SEL_SUM = 2'b00,
      SEL_AND = 2'b01,
      SEL_OR  = 2'b10,
      SEL_XOR = 2'b11
   } alu_sel_e;

   typedef struct packed {
      logic     sub;
      alu_sel_e sel;
   } alu_func_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   input  logic             sub,
   output logic [WIDTH-1:0] sum,
   output logic             carry_msb_in,
   output logic             carry_msb_out
);
   logic [WIDTH:0]   chain;
   logic [WIDTH-1:0] b_eff;

   assign chain[0] = sub;

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign b_eff[i]   = b[i] ^ sub;
      assign sum[i]     = a[i] ^ b_eff[i] ^ chain[i];
      assign chain[i+1] = (a[i] & b_eff[i]) | (a[i] & chain[i]) | (b_eff[i] & chain[i]);
   end

   assign carry_msb_in  = chain[WIDTH-1];
   assign carry_msb_out = chain[WIDTH];
endmodule

// File: rtl/alu_outmux.sv
module alu_outmux
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  alu_sel_e         sel,
   input  logic [WIDTH-1:0] sum,
   input  logic [WIDTH-1:0] a,
   input  logic [WIDTH-1:0] b,
   output logic [WIDTH-1:0] y
);
   always_comb begin
      unique case (sel)
         SEL_SUM: y = sum;
         SEL_AND: y = a & b;
         SEL_OR:  y = a | b;
         SEL_XOR: y = a ^ b;
         default: y = sum;
      endcase
   end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] y,
   input  logic             cin_msb,
   input  logic             cout_msb,
   output logic             n,
   output logic             z,
   output logic             v,
   output logic             c
);
   assign n = y[WIDTH-1];
   assign z = ~|y;
   assign v = cin_msb ^ cout_msb;
   assign c = cout_msb;
endmodule

// File: rtl/alu_nzvc.sv
module alu_nzvc
   import alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [2:0]       func,
   output logic [WIDTH-1:0] result,
   output logic             flag_n,
   output logic             flag_z,
   output logic             flag_v,
   output logic             flag_c
);
   if (WIDTH < 2) begin : g_bad_width
      $error("alu_nzvc: WIDTH must be at least 2");
   end

   alu_func_t        fc;
   logic [WIDTH-1:0] sum;
   logic             c_in_top;
   logic             c_out_top;

   assign fc = alu_func_t'(func);

   alu_addsub #(.WIDTH(WIDTH)) u_addsub (
      .a             (opa),
      .b             (opb),
      .sub           (fc.sub),
      .sum           (sum),
      .carry_msb_in  (c_in_top),
      .carry_msb_out (c_out_top)
   );

   alu_outmux #(.WIDTH(WIDTH)) u_mux (
      .sel (fc.sel),
      .sum (sum),
      .a   (opa),
      .b   (opb),
      .y   (result)
   );

   alu_flags #(.WIDTH(WIDTH)) u_flags (
      .y        (result),
      .cin_msb  (c_in_top),
      .cout_msb (c_out_top),
      .n        (flag_n),
      .z        (flag_z),
      .v        (flag_v),
      .c        (flag_c)
   );
endmodule

// File: rtl/alu_nzvc_chk.sv
module alu_nzvc_chk #(
   parameter int WIDTH = 32
) (
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic [2:0]       func,
   input logic [WIDTH-1:0] result,
   input logic             flag_n,
   input logic             flag_z,
   input logic             flag_v,
   input logic             flag_c
);
   logic [WIDTH:0] wide_add;

   always_comb begin
      wide_add = {1'b0, opa} + {1'b0, opb};
      // R1
      add_sum_chk: assert (func != 3'b000 || result == wide_add[WIDTH-1:0])
         else $error("add_sum_chk");
      // R2
      sub_diff_chk: assert (func != 3'b100 || result == opa - opb)
         else $error("sub_diff_chk");
      // R3
      and_sel_chk: assert (func[1:0] != 2'b01 || result == (opa & opb))
         else $error("and_sel_chk");
      // R3
      xor_sel_chk: assert (func[1:0] != 2'b11 || result == (opa ^ opb))
         else $error("xor_sel_chk");
      // R4
      sign_flag_chk: assert (flag_n == result[WIDTH-1])
         else $error("sign_flag_chk");
      // R5
      zero_flag_chk: assert (flag_z == (result == '0))
         else $error("zero_flag_chk");
      // R6
      add_carry_chk: assert (func[2] || flag_c == wide_add[WIDTH])
         else $error("add_carry_chk");
      // R7
      no_overflow_chk: assert (func != 3'b000 ||
                               flag_v == ((opa[WIDTH-1] == opb[WIDTH-1]) &&
                                          (result[WIDTH-1] != opa[WIDTH-1])))
         else $error("no_overflow_chk");
   end
endmodule

bind alu_nzvc alu_nzvc_chk #(.WIDTH(WIDTH)) u_chk (
   .opa    (opa),
   .opb    (opb),
   .func   (func),
   .result (result),
   .flag_n (flag_n),
   .flag_z (flag_z),
   .flag_v (flag_v),
   .flag_c (flag_c)
);

// File: tb/tb_alu_nzvc.sv
module tb_alu_nzvc;
   localparam int W = 32;

   typedef struct {
      logic [2:0]   f;
      logic [W-1:0] r;
      logic         n, z, v, c;
   } exp_t;

   logic         clk = 1'b0;
   logic [W-1:0] opa = '0, opb = '0;
   logic [2:0]   func = '0;
   logic [W-1:0] result;
   logic         flag_n, flag_z, flag_v, flag_c;

   int   total = 0, bad = 0;
   bit   stim_done = 1'b0;
   exp_t sb[$];

   always #5 clk = ~clk;

   alu_nzvc #(.WIDTH(W)) dut (
      .opa(opa), .opb(opb), .func(func), .result(result),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
   );

   function automatic exp_t model(input logic [W-1:0] a, input logic [W-1:0] b,
                                  input logic [2:0] f);
      exp_t        e;
      logic [W-1:0] bm;
      logic [W:0]   s;
      logic [W-1:0] lo;
      bm = f[2] ? ~b : b;
      s  = {1'b0, a} + {1'b0, bm} + {{W{1'b0}}, f[2]};
      lo = {1'b0, a[W-2:0]} + {1'b0, bm[W-2:0]} + {{(W-1){1'b0}}, f[2]};
      e.f = f;
      case (f[1:0])
         2'b00: e.r = s[W-1:0];
         2'b01: e.r = a & b;
         2'b10: e.r = a | b;
         default: e.r = a ^ b;
      endcase
      e.n = e.r[W-1];
      e.z = (e.r == '0);
      e.c = s[W];
      e.v = lo[W-1] ^ s[W];
      return e;
   endfunction

   task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] f);
      @(negedge clk);
      opa  = a;
      opb  = b;
      func = f;
      sb.push_back(model(a, b, f));
   endtask

   task automatic chk1(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h (a=%h b=%h f=%b)", tag, act, exp, opa, opb, func);
      end
   endtask

   // monitor: compare one expected item per rising edge
   always @(posedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         if (e.f == 3'b000)      chk1("R1 sum", result, e.r);
         else if (e.f == 3'b100) chk1("R2 difference", result, e.r);
         else if (e.f[1:0] != 2'b00) chk1("R3 logic select", result, e.r);
         else chk1("R1 sum", result, e.r);
         chk1("R4 flag_n", {{(W-1){1'b0}}, flag_n}, {{(W-1){1'b0}}, e.n});
         chk1("R5 flag_z", {{(W-1){1'b0}}, flag_z}, {{(W-1){1'b0}}, e.z});
         chk1("R6 flag_c", {{(W-1){1'b0}}, flag_c}, {{(W-1){1'b0}}, e.c});
         chk1("R7 flag_v", {{(W-1){1'b0}}, flag_v}, {{(W-1){1'b0}}, e.v});
      end
   end

   logic [W-1:0] corner [4];

   initial begin
      corner[0] = 32'h0000_0000;
      corner[1] = 32'hFFFF_FFFF;
      corner[2] = 32'h7FFF_FFFF;
      corner[3] = 32'h8000_0000;
      // corner operands under all eight codes (R1..R7)
      for (int f = 0; f < 8; f++)
         for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
               drive(corner[i], corner[j], 3'(f));
      // directed: equal operands subtract to zero, carry set (R2, R5, R6)
      drive(32'h1234_5678, 32'h1234_5678, 3'b100);
      // logic with subtract bit set uses plain opb (R3)
      drive(32'hF0F0_1234, 32'h0FF0_00FF, 3'b101);
      drive(32'hF0F0_1234, 32'h0FF0_00FF, 3'b110);
      drive(32'hF0F0_1234, 32'h0FF0_00FF, 3'b111);
      // random operands
      for (int k = 0; k < 400; k++)
         drive($urandom, $urandom, 3'($urandom_range(0, 7)));
      @(negedge clk);
      @(negedge clk);
      stim_done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (stim_done && sb.size() == 0);
         end
         begin
            repeat (20000) @(posedge clk);
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
         end
      join_any
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule